// File: doc/BRIEF.md
# Two-Bit Branch Predictor with Pipeline Flush

This unit predicts the direction and destination of branches in a short in-order pipeline. Each cycle the fetch stage presents the PC it is about to fetch. The unit looks that PC up in a small direct-mapped table and returns a taken/not-taken guess, a predicted destination and the next fetch address. The guess travels down the pipeline with the instruction. When the branch reaches execute, the execute stage sends back the branch PC, the real outcome, the real destination and the guess that came with it.

The unit compares the carried guess with the real outcome. It updates that branch's two-bit saturating counter, and on a taken outcome it also records the destination. If the guess was wrong, the unit drives a correction PC and raises flush requests for the decode and execute stages, all in the same cycle. When a correction and a fetch lookup happen together, the correction wins the next-PC choice.

Top module: `bp_unit`

## Requirements
- R1: After reset every entry holds counter value 01 (weakly not-taken) with its valid bit clear. Every PC therefore predicts not-taken, and a single taken resolution is enough to make that entry predict taken.
- R2: The table has 16 entries, indexed by PC bits [5:2]. Two PCs that agree in bits [5:2] share an entry, whatever their other bits are.
- R3: When the prediction is not-taken, `pred_target` is PC+4. The prediction is not-taken when the entry is invalid or counter bit 1 is 0. Without a flush, `next_pc` equals `pred_target`.
- R4: Counter encoding is 00 strong-not-taken, 01 weak-not-taken, 10 weak-taken and 11 strong-taken, and counter bit 1 is the predicted direction. Each resolution adds one (taken) or subtracts one (not-taken), saturating at 11 and at 00.
- R5: A taken resolution stores the resolved destination in the entry and sets its valid bit. A later taken prediction from that entry returns the stored destination.
- R6: A resolution is a misprediction when the real direction differs from the carried guess, or when both are taken and the destinations differ. `flush_dec` and `flush_exe` are high in exactly the cycles in which a valid resolution is a misprediction.
- R7: During a flush, `correct_pc` is the resolved destination if the branch was taken, and the branch PC+4 if it was not.
- R8: During a flush, `next_pc` equals `correct_pc`, overriding the fetch-side prediction of the same cycle.
- R9: A resolution changes the table at the clock edge that ends its cycle. A lookup in the same cycle sees the old entry, and a lookup in the following cycle sees the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | 32 | PC being fetched this cycle |
| pred_taken | output | 1 | Predicted direction for fetch_pc |
| pred_target | output | 32 | Predicted destination (PC+4 when not taken) |
| next_pc | output | 32 | Address for fetch to use next |
| res_valid | input | 1 | Execute presents a resolved branch |
| res_pc | input | 32 | PC of the resolved branch |
| res_taken | input | 1 | Real direction |
| res_target | input | 32 | Real taken destination |
| res_pred_taken | input | 1 | Direction guess carried with the branch |
| res_pred_target | input | 32 | Destination guess carried with the branch |
| flush_dec | output | 1 | Discard the instruction in decode |
| flush_exe | output | 1 | Discard the instruction in execute |
| correct_pc | output | 32 | Redirect address during a flush |

## Verification
The assertions check the relations that must hold in every cycle. They cover flush only on a valid resolution that differs from its carried guess (R6), the choice of correction address (R7), the priority of the correction in `next_pc` (R8), and sequential fetch on a not-taken prediction (R3). How a counter moves across resolutions, including saturation at both ends, weak-not-taken reset, target learning, aliasing between PCs and the one-cycle visibility of an update only show up over sequences of events. The bench's scenarios cover these by comparing against a behavioural table model on every clock.

// File: rtl/bp_pkg.sv
// Package: shared counter type and saturating update for the branch predictor.
// Assumes a 2-bit counter whose upper bit is the predicted direction.
package bp_pkg;
    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_STRONG_NT = 2'b00;
    localparam ctr_t CTR_WEAK_NT   = 2'b01;
    localparam ctr_t CTR_WEAK_T    = 2'b10;
    localparam ctr_t CTR_STRONG_T  = 2'b11;

    // Move the counter one step toward the observed outcome, clamping at the ends.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        if (taken)
            nxt = (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
        else
            nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
        return nxt;
    endfunction
endpackage

// File: rtl/bp_table.sv
// Module: bp_table
// Direct-mapped storage of counter, valid bit and destination per entry.
// One combinational read port, one write port applied at the clock edge.
// Assumes the caller supplies indices already extracted from the PC.
module bp_table
    import bp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    output logic             rd_valid,
    output logic [PC_W-1:0]  rd_tgt,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken,
    input  logic [PC_W-1:0]  wr_tgt
);
    localparam int ENTRIES = 1 << IDX_W;

    ctr_t            ctr_q [ENTRIES];
    logic            val_q [ENTRIES];
    logic [PC_W-1:0] tgt_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(e));

        // Per-entry state: reset to weak-not-taken, step on each resolution hit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctr_q[e] <= CTR_WEAK_NT;
                val_q[e] <= 1'b0;
                tgt_q[e] <= '0;
            end else if (hit) begin
                ctr_q[e] <= ctr_step(ctr_q[e], wr_taken);
                if (wr_taken) begin
                    val_q[e] <= 1'b1;
                    tgt_q[e] <= wr_tgt;
                end
            end
        end
    end

    // Read port: current (pre-update) contents of the addressed entry.
    always_comb begin
        rd_ctr   = ctr_q[rd_idx];
        rd_valid = val_q[rd_idx];
        rd_tgt   = tgt_q[rd_idx];
    end
endmodule

// File: rtl/bp_resolve.sv
// Module: bp_resolve
// Compares the guess carried with a branch against its real outcome and
// produces the misprediction flag and the redirect address.
// Assumes resolution inputs are meaningful only while res_valid is high.
module bp_resolve #(
    parameter int PC_W = 32
) (
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic [PC_W-1:0] res_target,
    input  logic            res_pred_taken,
    input  logic [PC_W-1:0] res_pred_target,
    output logic            miss,
    output logic [PC_W-1:0] redirect_pc
);
    logic dir_wrong;
    logic tgt_wrong;

    // Misprediction: wrong direction, or right direction (taken) with wrong destination.
    always_comb begin
        dir_wrong = res_taken != res_pred_taken;
        tgt_wrong = res_taken && res_pred_taken && (res_target != res_pred_target);
        miss      = res_valid && (dir_wrong || tgt_wrong);
    end

    // Redirect to the real destination, or fall through after the branch.
    always_comb begin
        redirect_pc = res_taken ? res_target : res_pc + PC_W'(4);
    end
endmodule

// File: rtl/bp_nextpc.sv
// Module: bp_nextpc
// Chooses the fetch address: a pending redirect overrides the prediction.
// Assumes pred_tgt already holds PC+4 for a not-taken prediction.
module bp_nextpc #(
    parameter int PC_W = 32
) (
    input  logic            redirect,
    input  logic [PC_W-1:0] redirect_pc,
    input  logic [PC_W-1:0] pred_tgt,
    output logic [PC_W-1:0] next_pc
);
    // Priority select between correction and prediction.
    always_comb begin
        next_pc = redirect ? redirect_pc : pred_tgt;
    end
endmodule

// File: rtl/bp_unit.sv
// Module: bp_unit (top)
// Two-bit branch predictor with decode/execute flush on misprediction.
// Fetch lookup is combinational on fetch_pc; resolution from execute updates
// the table at the following clock edge. Assumes word-aligned PCs.
module bp_unit
    import bp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 4,
    parameter int IDX_LSB = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     fetch_pc,
    output logic            pred_taken,
    output logic [31:0]     pred_target,
    output logic [31:0]     next_pc,
    input  logic            res_valid,
    input  logic [31:0]     res_pc,
    input  logic            res_taken,
    input  logic [31:0]     res_target,
    input  logic            res_pred_taken,
    input  logic [31:0]     res_pred_target,
    output logic            flush_dec,
    output logic            flush_exe,
    output logic [31:0]     correct_pc
);
    localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

    logic [IDX_W-1:0] f_idx;
    logic [IDX_W-1:0] r_idx;
    ctr_t             f_ctr;
    logic             f_valid;
    logic [PC_W-1:0]  f_tgt;
    logic             miss;

    // Table indices from the configured PC bit slice.
    always_comb begin
        f_idx = fetch_pc[IDX_MSB:IDX_LSB];
        r_idx = res_pc[IDX_MSB:IDX_LSB];
    end

    bp_table #(.PC_W(PC_W), .IDX_W(IDX_W)) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (f_idx),
        .rd_ctr   (f_ctr),
        .rd_valid (f_valid),
        .rd_tgt   (f_tgt),
        .wr_en    (res_valid),
        .wr_idx   (r_idx),
        .wr_taken (res_taken),
        .wr_tgt   (res_target)
    );

    // Fetch-side guess: only a valid entry with upper counter bit set predicts taken.
    always_comb begin
        pred_taken  = f_valid && f_ctr[1];
        pred_target = pred_taken ? f_tgt : fetch_pc + PC_W'(4);
    end

    bp_resolve #(.PC_W(PC_W)) i_resolve (
        .res_valid       (res_valid),
        .res_pc          (res_pc),
        .res_taken       (res_taken),
        .res_target      (res_target),
        .res_pred_taken  (res_pred_taken),
        .res_pred_target (res_pred_target),
        .miss            (miss),
        .redirect_pc     (correct_pc)
    );

    bp_nextpc #(.PC_W(PC_W)) i_nextpc (
        .redirect    (miss),
        .redirect_pc (correct_pc),
        .pred_tgt    (pred_target),
        .next_pc     (next_pc)
    );

    // Both younger stages are discarded on the same miss.
    always_comb begin
        flush_dec = miss;
        flush_exe = miss;
    end
endmodule

// File: rtl/bp_unit_checker.sv
// Module: bp_unit_checker
// Per-cycle properties of the predictor's ports; attached by bind.
module bp_unit_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] fetch_pc,
    input logic        pred_taken,
    input logic [31:0] pred_target,
    input logic [31:0] next_pc,
    input logic        res_valid,
    input logic [31:0] res_pc,
    input logic        res_taken,
    input logic [31:0] res_target,
    input logic        res_pred_taken,
    input logic [31:0] res_pred_target,
    input logic        flush_dec,
    input logic        flush_exe,
    input logic [31:0] correct_pc
);
    AST_FLUSH_NEEDS_RES: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!flush_dec && !flush_exe)); // R6
    AST_FLUSH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        flush_dec == flush_exe); // R6
    AST_NO_FLUSH_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_taken == res_pred_taken && (!res_taken || res_target == res_pred_target))
        |-> !flush_dec); // R6
    AST_FLUSH_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken != res_pred_taken) |-> flush_dec); // R6
    AST_CORRECT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_dec && res_taken) |-> correct_pc == res_target); // R7
    AST_CORRECT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_dec && !res_taken) |-> correct_pc == res_pc + 32'd4); // R7
    AST_REDIRECT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_dec |-> next_pc == correct_pc); // R8
    AST_SEQ_ON_NT: assert property (@(posedge clk) disable iff (!rst_n)
        (!pred_taken && !flush_dec) |-> next_pc == fetch_pc + 32'd4); // R3
    AST_PRED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_dec |-> next_pc == pred_target); // R3
endmodule

bind bp_unit bp_unit_checker i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_pc        (fetch_pc),
    .pred_taken      (pred_taken),
    .pred_target     (pred_target),
    .next_pc         (next_pc),
    .res_valid       (res_valid),
    .res_pc          (res_pc),
    .res_taken       (res_taken),
    .res_target      (res_target),
    .res_pred_taken  (res_pred_taken),
    .res_pred_target (res_pred_target),
    .flush_dec       (flush_dec),
    .flush_exe       (flush_exe),
    .correct_pc      (correct_pc)
);

// File: tb/test_bp_unit.sv
// Bench: behavioural table model compared with the predictor on every clock.
module test_bp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_taken;
    logic [31:0] pred_target;
    logic [31:0] next_pc;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic [31:0] res_target = '0;
    logic        res_pred_taken = 1'b0;
    logic [31:0] res_pred_target = '0;
    logic        flush_dec;
    logic        flush_exe;
    logic [31:0] correct_pc;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    string tag = "R1";

    // Model state: counter as integer 0..3, valid flag, stored destination.
    int          m_cnt [16];
    bit          m_val [16];
    logic [31:0] m_tgt [16];

    always #4 clk = ~clk;

    bp_unit i_bp_unit (.*);

    function automatic int slot(input logic [31:0] pc);
        return int'((pc >> 2) & 32'hF);
    endfunction

    function automatic bit m_taken(input logic [31:0] pc);
        return m_val[slot(pc)] && (m_cnt[slot(pc)] >= 2);
    endfunction

    function automatic logic [31:0] m_dest(input logic [31:0] pc);
        return m_taken(pc) ? m_tgt[slot(pc)] : pc + 32'd4;
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, compare all outputs, then advance the model.
    task automatic step(input logic [31:0] fpc, input bit rv, input logic [31:0] rpc,
                        input bit rt, input logic [31:0] rtgt,
                        input bit rpt, input logic [31:0] rptgt);
        bit miss;
        logic [31:0] corr;
        @(negedge clk);
        fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_taken = rt;
        res_target = rtgt; res_pred_taken = rpt; res_pred_target = rptgt;
        #2;
        miss = rv && ((rt != rpt) || (rt && rpt && rtgt != rptgt));
        corr = rt ? rtgt : rpc + 32'd4;
        check("pred_taken", {31'd0, pred_taken}, {31'd0, m_taken(fpc)});
        check("pred_target", pred_target, m_dest(fpc));
        check("flush_dec", {31'd0, flush_dec}, {31'd0, miss});
        check("flush_exe", {31'd0, flush_exe}, {31'd0, miss});
        check("next_pc", next_pc, miss ? corr : m_dest(fpc));
        if (miss) check("correct_pc", correct_pc, corr);
        @(posedge clk);
        if (rv) begin
            if (rt) begin
                if (m_cnt[slot(rpc)] < 3) m_cnt[slot(rpc)]++;
                m_val[slot(rpc)] = 1'b1;
                m_tgt[slot(rpc)] = rtgt;
            end else if (m_cnt[slot(rpc)] > 0) begin
                m_cnt[slot(rpc)]--;
            end
        end
    endtask

    // Resolution that carries the model's current guess for its PC.
    task automatic resolve(input logic [31:0] fpc, input logic [31:0] rpc,
                           input bit rt, input logic [31:0] rtgt);
        step(fpc, 1'b1, rpc, rt, rtgt, m_taken(rpc), m_dest(rpc));
    endtask

    task automatic idle(input logic [31:0] fpc);
        step(fpc, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_cnt[i] = 1; m_val[i] = 1'b0; m_tgt[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        tag = "R1";   // reset: everything not-taken, sequential
        for (int k = 0; k < 16; k++) idle(32'h1000 + 32'(k * 4));

        tag = "R1_R6"; // first taken resolution mispredicts, one step makes it taken
        resolve(32'h0000_0100, 32'h0000_0100, 1'b1, 32'h0000_0400);
        tag = "R5";
        idle(32'h0000_0100);
        check("R5 learned target", pred_target, 32'h0000_0400);

        tag = "R9";   // same-cycle lookup sees old entry, next cycle sees new
        resolve(32'h0000_0204, 32'h0000_0204, 1'b1, 32'h0000_0800);
        check("R9 old entry seen", {31'd0, pred_taken}, 32'd0);
        idle(32'h0000_0204);
        check("R9 new entry seen", {31'd0, pred_taken}, 32'd1);

        tag = "R4";   // climb to strong-taken, then step down two
        for (int k = 0; k < 4; k++) resolve(32'h0000_0100, 32'h0000_0100, 1'b1, 32'h0000_0400);
        resolve(32'h0000_0100, 32'h0000_0100, 1'b0, 32'h0);
        idle(32'h0000_0100);
        check("R4 still taken after one drop", {31'd0, pred_taken}, 32'd1);
        resolve(32'h0000_0100, 32'h0000_0100, 1'b0, 32'h0);
        idle(32'h0000_0100);
        check("R4 not taken after two drops", {31'd0, pred_taken}, 32'd0);

        tag = "R2";   // alias on bits [5:2]
        resolve(32'h0000_0300, 32'h0000_0100, 1'b1, 32'h0000_0400);
        idle(32'h0000_1100);
        check("R2 alias predicts taken", {31'd0, pred_taken}, 32'd1);
        idle(32'h0000_1104);

        tag = "R6";   // right direction, wrong destination
        step(32'h0000_0040, 1'b1, 32'h0000_0100, 1'b1, 32'h0000_0500, 1'b1, 32'h0000_0400);
        tag = "R5";
        idle(32'h0000_0100);
        check("R5 retargeted", pred_target, 32'h0000_0500);

        tag = "R7";   // not-taken miss falls through after the branch
        resolve(32'h0000_0020, 32'h0000_0100, 1'b1, 32'h0000_0500);
        step(32'h0000_0020, 1'b1, 32'h0000_0100, 1'b0, 32'h0000_0500, 1'b1, 32'h0000_0500);
        check("R7 fallthrough", correct_pc, 32'h0000_0104);

        tag = "R8";   // correction overrides a taken fetch prediction
        step(32'h0000_0204, 1'b1, 32'h0000_0038, 1'b1, 32'h0000_0900, 1'b0, 32'h0000_003C);
        check("R8 priority", next_pc, 32'h0000_0900);

        tag = "R4_low"; // saturate at strong-not-taken
        for (int k = 0; k < 4; k++) resolve(32'h0000_0010, 32'h0000_0010, 1'b0, 32'h0);
        resolve(32'h0000_0010, 32'h0000_0010, 1'b1, 32'h0000_0700);
        idle(32'h0000_0010);
        check("R4 low saturation", {31'd0, pred_taken}, 32'd0);

        tag = "R6_hit"; // correct predictions produce no flush
        resolve(32'h0000_0204, 32'h0000_0204, 1'b1, 32'h0000_0800);
        resolve(32'h0000_0008, 32'h0000_0008, 1'b0, 32'h0);
        idle(32'h0000_0204);

        tag = "R3";
        idle(32'h0000_0030);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule